// File: doc/BRIEF.md
# Fast System-Call Entry Unit

This block computes the full architectural state change for a fast system-call instruction in a single combinational step and registers the result for one cycle of handshake. The caller pulses `start` with the current instruction pointer, the instruction length, the flags and the processor-mode indicators. The caller also supplies four model-specific target registers: a packed selector/legacy-target register, the long-mode 64-bit entry point, the compatibility-mode entry point and the flag-clear mask. One cycle later `done` pulses. The new selectors, their cached descriptor attributes, the new instruction pointer, the new flags and the values to save into the return-address and saved-flags registers are then on the outputs, along with write-enable strobes for each group.

The unit chooses between three entry targets and two flag-clearing rules according to mode. It derives both segment selectors from one 16-bit field of the packed register. When the system-call enable bit is clear, it reports an invalid-opcode fault, drops all write enables and leaves every data output at its earlier value.

Top module: `fastcall_entry`

## Requirements
- R1: When `start` is sampled with `sysEnable` low, the next cycle shows `fault`=1 and `faultCode`=0, with `wrState`=0 and `wrSavedFlags`=0. Every data output keeps the value it had before.
- R2: On a committed call, `codeSel` is bits 47:32 of `selTargetReg` with bits 1:0 cleared. `stackSel` is that 16-bit field plus 8, modulo 2^16, with bits 1:0 cleared.
- R3: In long mode (`longMode`=1), `savedRet` is `curIp`+`instLen` over the full 64 bits. `savedFlags` is `flagsIn` with bit 16 (resume) cleared, and `wrSavedFlags` is 1.
- R4: In long mode, `newFlags` is `flagsIn` with every bit set in `flagMask` cleared, and with bit 16 cleared as well.
- R5: In long mode, `newIp` is `longTarget` when `code64`=1 and `compatTarget` when `code64`=0.
- R6: In legacy mode (`longMode`=0), `savedRet` is the low 32 bits of `curIp`+`instLen`, zero-extended. `newFlags` is `flagsIn` with bits 9 (interrupt), 16 (resume) and 17 (virtual-8086) cleared. `newIp` is the zero-extended low 32 bits of `selTargetReg`, and `wrSavedFlags` is 0 with `savedFlags` unchanged.
- R7: On a committed call, `segBase`=0 and `segLimit`=0xFFFFFFFF. The attribute vectors use bit 7 granularity, 6 big/default-size, 5 long-code, 4 present, 3 user segment, 2 code, 1 readable/writable and 0 accessed. `stackAttr`=0xDB.
- R8: `codeAttr` is 0xBF in long mode (long-code set, default-size clear) and 0xDF in legacy mode (default-size set, long-code clear).
- R9: `done` is high exactly in the cycle after each cycle in which `start` was sampled high. `fault`, `wrState` and `wrSavedFlags` are low whenever `done` is low.
- R10: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to execute one system-call entry |
| sysEnable | input | 1 | System-call enable bit of the extended feature register |
| longMode | input | 1 | Long mode active |
| code64 | input | 1 | Calling code segment is 64-bit |
| selTargetReg | input | 64 | Packed register: selector base in 47:32, legacy target in 31:0 |
| longTarget | input | 64 | Entry point for 64-bit callers |
| compatTarget | input | 64 | Entry point for compatibility-mode callers |
| flagMask | input | 32 | Flags to clear on long-mode entry |
| flagsIn | input | 32 | Current flags |
| curIp | input | 64 | Instruction pointer of the call |
| instLen | input | 4 | Length of the call instruction |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Invalid-opcode fault |
| faultCode | output | 16 | Error code of the fault (always 0) |
| wrState | output | 1 | Write enable for IP, flags, segments and return address |
| wrSavedFlags | output | 1 | Write enable for the saved-flags register |
| newIp | output | 64 | New instruction pointer |
| newFlags | output | 32 | New flags |
| codeSel | output | 16 | New code selector |
| stackSel | output | 16 | New stack selector |
| codeAttr | output | 8 | Cached code segment attributes |
| stackAttr | output | 8 | Cached stack segment attributes |
| segBase | output | 32 | Cached base of both segments |
| segLimit | output | 32 | Cached limit of both segments |
| savedRet | output | 64 | Return address to save |
| savedFlags | output | 32 | Flags image to save |

## Verification
A completion and a fault can fall on consecutive cycles. In that case the result registers must hold the data of the committed call while `fault` rises. The bench provokes this by holding `start` for two cycles and dropping `sysEnable` between them. It also issues a legacy call right after a long-mode call, so that `savedFlags` must keep the long-mode image while everything else changes. A behavioural reference model compares every output on every clock, so a stale or wrongly updated register shows up in the very cycle it diverges.

// File: rtl/fce_pkg.sv
package fce_pkg;
  localparam int IF_BIT = 9;
  localparam int RF_BIT = 16;
  localparam int VM_BIT = 17;

  typedef struct packed {
    logic gran;
    logic big;
    logic longCode;
    logic present;
    logic userSeg;
    logic isCode;
    logic rdWr;
    logic accessed;
  } segAttr_t;

  typedef struct packed {
    logic commit;
    logic fault;
    logic saveFlags;
  } strobe_t;
endpackage

// File: rtl/fce_control.sv
module fce_control
  import fce_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    sysEnable,
  input  logic    longMode,
  output strobe_t strobes,
  output logic    done
);
  always_comb begin
    strobes.commit    = start & sysEnable;
    strobes.fault     = start & ~sysEnable;
    strobes.saveFlags = start & sysEnable & longMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) done <= 1'b0;
    else       done <= start;
  end
endmodule

// File: rtl/fce_datapath.sv
module fce_datapath
  import fce_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int FLAG_W  = 32,
  parameter int SEL_W   = 16,
  parameter int SEL_LSB = 32,
  parameter int LEN_W   = 4,
  parameter int SEG_W   = 32,
  parameter int ERR_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic              longMode,
  input  logic              code64,
  input  logic [ADDR_W-1:0] selTargetReg,
  input  logic [ADDR_W-1:0] longTarget,
  input  logic [ADDR_W-1:0] compatTarget,
  input  logic [FLAG_W-1:0] flagMask,
  input  logic [FLAG_W-1:0] flagsIn,
  input  logic [ADDR_W-1:0] curIp,
  input  logic [LEN_W-1:0]  instLen,
  output logic              fault,
  output logic [ERR_W-1:0]  faultCode,
  output logic              wrState,
  output logic              wrSavedFlags,
  output logic [ADDR_W-1:0] newIp,
  output logic [FLAG_W-1:0] newFlags,
  output logic [SEL_W-1:0]  codeSel,
  output logic [SEL_W-1:0]  stackSel,
  output segAttr_t          codeAttr,
  output segAttr_t          stackAttr,
  output logic [SEG_W-1:0]  segBase,
  output logic [SEG_W-1:0]  segLimit,
  output logic [ADDR_W-1:0] savedRet,
  output logic [FLAG_W-1:0] savedFlags
);
  localparam int LEGACY_W = 32;
  localparam logic [SEL_W-1:0]  RPL_CLR = ~SEL_W'(3);
  localparam logic [SEL_W-1:0]  SS_STEP = SEL_W'(8);
  localparam logic [FLAG_W-1:0] RF_M = FLAG_W'(1) << RF_BIT;
  localparam logic [FLAG_W-1:0] IF_M = FLAG_W'(1) << IF_BIT;
  localparam logic [FLAG_W-1:0] VM_M = FLAG_W'(1) << VM_BIT;

  logic [ADDR_W-1:0] nextIp, ipC, retC;
  logic [FLAG_W-1:0] flagsC, saveC;
  logic [SEL_W-1:0]  baseSel, csC, ssC;
  segAttr_t          csAttrC, ssAttrC;

  always_comb begin
    nextIp  = curIp + ADDR_W'(instLen);
    baseSel = selTargetReg[SEL_LSB +: SEL_W];
    csC     = baseSel & RPL_CLR;
    ssC     = (baseSel + SS_STEP) & RPL_CLR;
    saveC   = flagsIn & ~RF_M;

    csAttrC = '{gran: 1'b1, big: ~longMode, longCode: longMode, present: 1'b1,
                userSeg: 1'b1, isCode: 1'b1, rdWr: 1'b1, accessed: 1'b1};
    ssAttrC = '{gran: 1'b1, big: 1'b1, longCode: 1'b0, present: 1'b1,
                userSeg: 1'b1, isCode: 1'b0, rdWr: 1'b1, accessed: 1'b1};

    if (longMode) begin
      retC   = nextIp;
      flagsC = flagsIn & ~(flagMask | RF_M);
      ipC    = code64 ? longTarget : compatTarget;
    end else begin
      retC   = ADDR_W'(nextIp[LEGACY_W-1:0]);
      flagsC = flagsIn & ~(IF_M | RF_M | VM_M);
      ipC    = ADDR_W'(selTargetReg[LEGACY_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fault        <= 1'b0;
      wrState      <= 1'b0;
      wrSavedFlags <= 1'b0;
    end else begin
      fault        <= strobes.fault;
      wrState      <= strobes.commit;
      wrSavedFlags <= strobes.saveFlags;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      newIp     <= '0;
      newFlags  <= '0;
      codeSel   <= '0;
      stackSel  <= '0;
      codeAttr  <= '0;
      stackAttr <= '0;
      segBase   <= '0;
      segLimit  <= '0;
      savedRet  <= '0;
    end else if (strobes.commit) begin
      newIp     <= ipC;
      newFlags  <= flagsC;
      codeSel   <= csC;
      stackSel  <= ssC;
      codeAttr  <= csAttrC;
      stackAttr <= ssAttrC;
      segBase   <= '0;
      segLimit  <= '1;
      savedRet  <= retC;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  savedFlags <= '0;
    else if (strobes.saveFlags) savedFlags <= saveC;
  end

  assign faultCode = '0;
endmodule

// File: rtl/fastcall_entry.sv
module fastcall_entry
  import fce_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int FLAG_W = 32,
  parameter int SEL_W  = 16,
  parameter int LEN_W  = 4,
  parameter int SEG_W  = 32,
  parameter int ERR_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              sysEnable,
  input  logic              longMode,
  input  logic              code64,
  input  logic [ADDR_W-1:0] selTargetReg,
  input  logic [ADDR_W-1:0] longTarget,
  input  logic [ADDR_W-1:0] compatTarget,
  input  logic [FLAG_W-1:0] flagMask,
  input  logic [FLAG_W-1:0] flagsIn,
  input  logic [ADDR_W-1:0] curIp,
  input  logic [LEN_W-1:0]  instLen,
  output logic              done,
  output logic              fault,
  output logic [ERR_W-1:0]  faultCode,
  output logic              wrState,
  output logic              wrSavedFlags,
  output logic [ADDR_W-1:0] newIp,
  output logic [FLAG_W-1:0] newFlags,
  output logic [SEL_W-1:0]  codeSel,
  output logic [SEL_W-1:0]  stackSel,
  output logic [7:0]        codeAttr,
  output logic [7:0]        stackAttr,
  output logic [SEG_W-1:0]  segBase,
  output logic [SEG_W-1:0]  segLimit,
  output logic [ADDR_W-1:0] savedRet,
  output logic [FLAG_W-1:0] savedFlags
);
  strobe_t  strobes;
  segAttr_t csAttr, ssAttr;

  fce_control u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .sysEnable(sysEnable),
    .longMode(longMode), .strobes(strobes), .done(done)
  );

  fce_datapath #(
    .ADDR_W(ADDR_W), .FLAG_W(FLAG_W), .SEL_W(SEL_W),
    .LEN_W(LEN_W), .SEG_W(SEG_W), .ERR_W(ERR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .longMode(longMode), .code64(code64),
    .selTargetReg(selTargetReg), .longTarget(longTarget),
    .compatTarget(compatTarget), .flagMask(flagMask),
    .flagsIn(flagsIn), .curIp(curIp), .instLen(instLen),
    .fault(fault), .faultCode(faultCode), .wrState(wrState),
    .wrSavedFlags(wrSavedFlags), .newIp(newIp), .newFlags(newFlags),
    .codeSel(codeSel), .stackSel(stackSel),
    .codeAttr(csAttr), .stackAttr(ssAttr),
    .segBase(segBase), .segLimit(segLimit),
    .savedRet(savedRet), .savedFlags(savedFlags)
  );

  assign codeAttr  = csAttr;
  assign stackAttr = ssAttr;
endmodule

// File: rtl/fce_checker.sv
module fce_checker #(
  parameter int ADDR_W = 64,
  parameter int FLAG_W = 32,
  parameter int SEL_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              done,
  input logic              fault,
  input logic              wrState,
  input logic              wrSavedFlags,
  input logic [ADDR_W-1:0] newIp,
  input logic [FLAG_W-1:0] newFlags,
  input logic [SEL_W-1:0]  codeSel,
  input logic [SEL_W-1:0]  stackSel,
  input logic [7:0]        codeAttr,
  input logic [7:0]        stackAttr
);
  p_fault_no_write_r1: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> (!wrState && !wrSavedFlags));

  p_fault_keeps_ip_r1: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> ($stable(newIp) && $stable(newFlags) && $stable(codeSel)));

  p_sel_rpl_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrState |-> (codeSel[1:0] == 2'b00 && stackSel[1:0] == 2'b00));

  p_stack_after_code_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrState |-> (stackSel == codeSel + SEL_W'(8)));

  p_resume_cleared_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrState |-> !newFlags[16]);

  p_stack_attr_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrState |-> (stackAttr == 8'hDB));

  p_code_size_exclusive_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrState |-> (codeAttr[5] != codeAttr[6]));

  p_done_follows_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    start |=> done);

  p_no_done_without_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !done);

  p_strobes_need_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> (!fault && !wrState && !wrSavedFlags));
endmodule

bind fastcall_entry fce_checker #(
  .ADDR_W(ADDR_W), .FLAG_W(FLAG_W), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .done(done), .fault(fault),
  .wrState(wrState), .wrSavedFlags(wrSavedFlags), .newIp(newIp),
  .newFlags(newFlags), .codeSel(codeSel), .stackSel(stackSel),
  .codeAttr(codeAttr), .stackAttr(stackAttr)
);

// File: tb/fastcall_entry_test.sv
module fastcall_entry_test;
  logic        clk = 0;
  logic        rstN = 0;
  logic        start = 0, sysEnable = 0, longMode = 0, code64 = 0;
  logic [63:0] selTargetReg = 0, longTarget = 0, compatTarget = 0, curIp = 0;
  logic [31:0] flagMask = 0, flagsIn = 0;
  logic [3:0]  instLen = 0;
  logic        done, fault, wrState, wrSavedFlags;
  logic [15:0] faultCode, codeSel, stackSel;
  logic [63:0] newIp, savedRet;
  logic [31:0] newFlags, savedFlags, segBase, segLimit;
  logic [7:0]  codeAttr, stackAttr;

  int checks = 0, fails = 0;
  bit finished = 0, live = 0;

  fastcall_entry uut (.*);

  always #4 clk = ~clk;

  // reference model state
  bit          eDone, eFault, eWrS, eWrF;
  logic [63:0] eIp, eRet;
  logic [31:0] eFl, eSf, eBase, eLim;
  logic [15:0] eCs, eSs, selField;
  logic [7:0]  eCa, eSa;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {eDone, eFault, eWrS, eWrF} = 4'b0;
      eIp = 0; eRet = 0; eFl = 0; eSf = 0; eBase = 0; eLim = 0;
      eCs = 0; eSs = 0; eCa = 0; eSa = 0;
    end else begin
      eDone  = start;
      eFault = start && !sysEnable;
      eWrS   = start && sysEnable;
      eWrF   = start && sysEnable && longMode;
      if (start && sysEnable) begin
        selField = selTargetReg[47:32];
        eCs = {selField[15:2], 2'b00};
        selField = selField + 16'd8;
        eSs = {selField[15:2], 2'b00};
        eSa = 8'hDB; eBase = 0; eLim = 32'hFFFF_FFFF;
        if (longMode) begin
          eRet = curIp + {60'd0, instLen};
          eSf  = flagsIn & 32'hFFFE_FFFF;
          eFl  = flagsIn & ~flagMask & 32'hFFFE_FFFF;
          eIp  = code64 ? longTarget : compatTarget;
          eCa  = 8'hBF;
        end else begin
          eRet = (curIp + {60'd0, instLen}) & 64'h0000_0000_FFFF_FFFF;
          eFl  = flagsIn & 32'hFFFC_FDFF;
          eIp  = selTargetReg & 64'h0000_0000_FFFF_FFFF;
          eCa  = 8'hDF;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk(done == eDone, "R9 done", 64'(done), 64'(eDone));
    chk(fault == eFault && faultCode == 0, "R1 fault", {faultCode, 47'd0, fault}, 64'(eFault));
    chk(wrState == eWrS, "R1 wrState", 64'(wrState), 64'(eWrS));
    chk(wrSavedFlags == eWrF, "R3 wrSavedFlags", 64'(wrSavedFlags), 64'(eWrF));
    chk(codeSel == eCs && stackSel == eSs, "R2 selectors", {codeSel, stackSel}, {eCs, eSs});
    chk(newIp == eIp, "R5/R6 newIp", newIp, eIp);
    chk(newFlags == eFl, "R4/R6 newFlags", 64'(newFlags), 64'(eFl));
    chk(savedRet == eRet, "R3/R6 savedRet", savedRet, eRet);
    chk(savedFlags == eSf, "R3 savedFlags", 64'(savedFlags), 64'(eSf));
    chk(codeAttr == eCa, "R8 codeAttr", 64'(codeAttr), 64'(eCa));
    chk(stackAttr == eSa && segBase == eBase && segLimit == eLim, "R7 stack attr/base/limit",
        {stackAttr, segBase, segLimit[23:0]}, {eSa, eBase, eLim[23:0]});
  endtask

  always @(negedge clk) if (live && !finished) compareAll();

  task automatic issue(input bit en, input bit lm, input bit c64,
                       input logic [63:0] tgt, input logic [31:0] fl,
                       input logic [31:0] fm, input logic [63:0] ip,
                       input logic [3:0] len, input int hold);
    sysEnable = en; longMode = lm; code64 = c64; selTargetReg = tgt;
    flagsIn = fl; flagMask = fm; curIp = ip; instLen = len; start = 1;
    repeat (hold) @(negedge clk);
    start = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    longTarget   = 64'hFFFF_8000_1234_5670;
    compatTarget = 64'h0000_0000_00C0_FFEE;
    repeat (2) @(negedge clk);
    // R10: every output zero during reset
    chk({done, fault, wrState, wrSavedFlags} == 0 && newIp == 0 && savedRet == 0 &&
        newFlags == 0 && savedFlags == 0 && codeSel == 0 && stackSel == 0 &&
        codeAttr == 0 && stackAttr == 0 && segBase == 0 && segLimit == 0,
        "R10 reset outputs", newIp | savedRet, 64'd0);
    rstN = 1;
    live = 1;
    @(negedge clk);
    // R5: long mode, 64-bit caller; R4 mask with RF set
    issue(1, 1, 1, 64'h0000_0013_DEAD_BEEF, 32'h0003_0202, 32'h0000_0700, 64'h0000_7FFF_0000_1000, 4'd2, 1);
    // R5: long mode, compatibility caller, selector low bits set
    issue(1, 1, 0, 64'h0000_ABCB_0000_0010, 32'hFFFF_FFFF, 32'h0004_0001, 64'hFFFF_FFFF_FFFF_FFFF, 4'd2, 1);
    // R6: legacy call right after long call, savedFlags must hold
    issue(1, 0, 1, 64'h1234_0023_8000_4000, 32'h0003_0346, 32'hFFFF_FFFF, 64'h0000_0001_FFFF_FFFE, 4'd3, 1);
    // R2: selector field wraps when adding 8
    issue(1, 0, 0, 64'h0000_FFFE_0000_0000, 32'h0000_0002, 32'h0, 64'h100, 4'd15, 1);
    // R1: fault holds all data
    issue(0, 1, 1, 64'hFFFF_0000_FFFF_FFFF, 32'h0, 32'h0, 64'h55, 4'd1, 1);
    // R9 with R1: commit then fault on back-to-back start cycles
    sysEnable = 1; longMode = 1; code64 = 1; selTargetReg = 64'h0000_0043_0000_0000;
    flagsIn = 32'h0001_0200; flagMask = 32'h0000_0200; curIp = 64'h4000; instLen = 4'd5;
    start = 1;
    @(negedge clk);
    sysEnable = 0;
    @(negedge clk);
    start = 0;
    @(negedge clk);
    // R9: start held for three cycles, legacy
    issue(1, 0, 0, 64'h0000_0008_0000_0ABC, 32'h0002_0000, 32'h0, 64'hFFFF_FFFF_FFFF_FFF0, 4'd15, 3);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule